// File: doc/BRIEF.md
# Start/Stop Framed Word Aligner

The block sits behind a fixed-ratio deserializer on a single serial lane and takes one 6-bit nibble on every clock. The lane carries 12-bit frames: a start bit of value one, ten payload bits, and a stop bit of value zero. Each frame therefore spans exactly two nibbles' worth of bits. The frame boundary may fall at any bit position relative to the nibbles.

While training, the block searches every possible bit alignment for the training frame. The training payload can be all ones, in which case the stop bit is the only zero in the stream. It can also be all zeros, in which case the start bit is the only one. After a run of good frames at the same alignment the block declares lock. It then strips the framing bits and delivers each 10-bit payload with a one-cycle valid strobe.

Transmitter and receiver share a clock source, so the alignment found during training is kept without further tracking. Repeated framing failures drop lock. A sticky flag records framing faults seen while locked. A resync input or the reset sends the block back to searching.

Top module: `frame_aligner`

## Requirements
- R1: Within a nibble, bit 5 is the earliest received bit. A frame is start (1), ten payload bits, stop (0). The output word carries the first-received payload bit in bit 9 and the last in bit 0.
- R2: With `train_zeros_i` low, the training frame is 1 followed by ten ones and a 0. The block acquires it at every one of the 12 possible bit offsets relative to the nibble stream.
- R3: With `train_zeros_i` high, the training frame is 1 followed by ten zeros and a 0, and the all-ones training frame never leads to lock.
- R4: `locked_o` rises after the 8th consecutive frame with start=1 and stop=0 at the same offset, counting the detected training frame as the first. A bad frame before that point restarts the search.
- R5: While locked, each good frame produces exactly one word. `word_valid_o` is high for one cycle, the cycle after the clock edge that samples the nibble holding the frame's stop bit. No word is produced while unlocked or for a bad frame.
- R6: While locked, 4 consecutive bad frames clear `locked_o`. A good frame restarts that count.
- R7: `frame_err_o` is set by any bad frame while locked and stays set until `err_clr_i` is high on a clock edge. A new fault on that same edge keeps it set.
- R8: `resync_i` on a clock edge returns the block to search and clears `locked_o` on that edge. Any frame completing on that edge is discarded. Lock is regained only after a fresh run of 8 good frames.
- R9: After synchronous reset `locked_o`, `word_valid_o`, `frame_err_o` and `word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_i | input | 6 | Deserialized nibble, bit 5 received first |
| train_zeros_i | input | 1 | Selects all-zeros training payload (else all-ones) |
| resync_i | input | 1 | Restart the boundary search |
| err_clr_i | input | 1 | Clear the sticky framing-error flag |
| word_o | output | 10 | Payload of the last good locked frame |
| word_valid_o | output | 1 | One-cycle strobe per delivered word |
| locked_o | output | 1 | Frame alignment held |
| frame_err_o | output | 1 | Sticky framing fault seen while locked |

## Verification
Training at junk offsets 0, 1, 2, 3, 4, 5, 7, 9 and 11 bits covers both nibble phases and every in-nibble shift. Data words 155h, 2AAh, 001h and 200h after lock show whether bit order and alignment are right, since a one-bit slip or a reversal changes them. Feeding the all-ones pattern with zeros selected shows that acquisition depends on the full pattern, not only on the framing bits. Frames with a bad stop bit abort training. Frames with a bad start bit, placed between good frames, check that the loss counter restarts, that the error flag is sticky and can be cleared, and that a resync leads to a full recount.

// File: rtl/fa_pkg.sv
`timescale 1ns/1ps
package fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } fa_state_e;
endpackage

// File: rtl/fa_window.sv
`timescale 1ns/1ps
// Sliding history over the nibble stream. Presents one candidate frame per
// in-nibble shift; each candidate ends inside the current nibble.
module fa_window #(
  parameter int NIB_W   = 6,
  parameter int FRAME_W = 12
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NIB_W-1:0]                 nib_i,
  input  logic                             zeros_sel_i,
  output logic [NIB_W-1:0][FRAME_W-1:0]    win_o,
  output logic [NIB_W-1:0]                 train_hit_o,
  output logic [NIB_W-1:0]                 frame_ok_o
);
  localparam int HIST_W = FRAME_W - 1;
  localparam int CAT_W  = HIST_W + NIB_W;

  logic [HIST_W-1:0]  hist_q;
  logic [CAT_W-1:0]   cat;
  logic [FRAME_W-1:0] pattern;

  // Older bits sit at higher indices.
  assign cat     = {hist_q, nib_i};
  assign pattern = {1'b1, {(FRAME_W-2){~zeros_sel_i}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= cat[HIST_W-1:0];
  end

  for (genvar s = 0; s < NIB_W; s++) begin : g_shift
    assign win_o[s]       = cat[s +: FRAME_W];
    assign train_hit_o[s] = (cat[s +: FRAME_W] == pattern);
    assign frame_ok_o[s]  = cat[s + FRAME_W - 1] & ~cat[s];
  end
endmodule

// File: rtl/fa_sync_fsm.sv
`timescale 1ns/1ps
// Boundary search, confirmation and loss tracking. The offset is a pair of
// nibble phase and in-nibble shift: 2 x NIB_W candidates.
module fa_sync_fsm
  import fa_pkg::*;
#(
  parameter int NIB_W       = 6,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       resync_i,
  input  logic [NIB_W-1:0]           train_hit_i,
  input  logic [NIB_W-1:0]           frame_ok_i,
  output logic [$clog2(NIB_W)-1:0]   sel_sh_o,
  output logic                       locked_o,
  output logic                       good_o,
  output logic                       bad_o
);
  localparam int SH_W    = $clog2(NIB_W);
  localparam int CNT_MAX = (LOCK_FRAMES > LOSS_FRAMES) ? LOCK_FRAMES : LOSS_FRAMES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_FRAMES - 1);
  localparam logic [CNT_W-1:0] LOSS_LAST = CNT_W'(LOSS_FRAMES - 1);

  fa_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             lk_ph_q;
  logic [SH_W-1:0]  lk_sh_q;
  logic [SH_W-1:0]  hit_sh;
  logic             at_tick;
  logic             cur_ok;

  always_comb begin
    hit_sh = '0;
    for (int s = NIB_W - 1; s >= 0; s--) begin
      if (train_hit_i[s]) hit_sh = SH_W'(s);
    end
  end

  assign at_tick  = (ph_q == lk_ph_q);
  assign cur_ok   = frame_ok_i[lk_sh_q];
  assign sel_sh_o = lk_sh_q;
  assign locked_o = (st_q == ST_LOCKED);
  assign good_o   = locked_o && at_tick && cur_ok  && !resync_i;
  assign bad_o    = locked_o && at_tick && !cur_ok && !resync_i;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ~ph_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_SEARCH;
      cnt_q   <= '0;
      lk_ph_q <= 1'b0;
      lk_sh_q <= '0;
    end else if (resync_i) begin
      st_q  <= ST_SEARCH;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_SEARCH: begin
          if (|train_hit_i) begin
            lk_ph_q <= ph_q;
            lk_sh_q <= hit_sh;
            if (LOCK_FRAMES <= 1) begin
              st_q  <= ST_LOCKED;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_CONFIRM;
              cnt_q <= CNT_W'(1);
            end
          end
        end
        ST_CONFIRM: begin
          if (at_tick) begin
            if (!cur_ok) begin
              st_q  <= ST_SEARCH;
              cnt_q <= '0;
            end else if (cnt_q == LOCK_LAST) begin
              st_q  <= ST_LOCKED;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (at_tick) begin
            if (cur_ok) begin
              cnt_q <= '0;
            end else if (cnt_q == LOSS_LAST) begin
              st_q  <= ST_SEARCH;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_q  <= ST_SEARCH;
          cnt_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/fa_word_out.sv
`timescale 1ns/1ps
// Registered payload output, valid strobe and sticky framing-error flag.
module fa_word_out #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               err_clr_i,
  input  logic               good_i,
  input  logic               bad_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [DATA_W-1:0]  word_o,
  output logic               word_valid_o,
  output logic               frame_err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      word_valid_o <= good_i;
      if (good_i) word_o <= frame_i[FRAME_W-2:1];
      if (bad_i)          frame_err_o <= 1'b1;
      else if (err_clr_i) frame_err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_aligner.sv
`timescale 1ns/1ps
module frame_aligner #(
  parameter int NIB_W       = 6,
  parameter int DATA_W      = 10,
  parameter int LOCK_FRAMES = 8,
  parameter int LOSS_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              train_zeros_i,
  input  logic              resync_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              locked_o,
  output logic              frame_err_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int SH_W    = $clog2(NIB_W);

  logic [NIB_W-1:0][FRAME_W-1:0] win;
  logic [NIB_W-1:0]              train_hit;
  logic [NIB_W-1:0]              frame_ok;
  logic [SH_W-1:0]               sel_sh;
  logic                          good;
  logic                          bad;

  fa_window #(.NIB_W(NIB_W), .FRAME_W(FRAME_W)) u_window (
    .clk         (clk),
    .rst         (rst),
    .nib_i       (nib_i),
    .zeros_sel_i (train_zeros_i),
    .win_o       (win),
    .train_hit_o (train_hit),
    .frame_ok_o  (frame_ok)
  );

  fa_sync_fsm #(
    .NIB_W(NIB_W), .LOCK_FRAMES(LOCK_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .resync_i    (resync_i),
    .train_hit_i (train_hit),
    .frame_ok_i  (frame_ok),
    .sel_sh_o    (sel_sh),
    .locked_o    (locked_o),
    .good_o      (good),
    .bad_o       (bad)
  );

  fa_word_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .err_clr_i    (err_clr_i),
    .good_i       (good),
    .bad_i        (bad),
    .frame_i      (win[sel_sh]),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .frame_err_o  (frame_err_o)
  );
endmodule

// File: rtl/frame_aligner_chk.sv
`timescale 1ns/1ps
module frame_aligner_chk (
  input logic clk,
  input logic rst,
  input logic resync_i,
  input logic err_clr_i,
  input logic word_valid_o,
  input logic locked_o,
  input logic frame_err_o
);
  AST_VALID_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |-> locked_o); // R5
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o); // R5
  AST_LOSS_MARKS_ERR: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> ($past(resync_i) || frame_err_o)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (frame_err_o && !err_clr_i) |=> frame_err_o); // R7
  AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err_o) |-> $past(locked_o)); // R7
  AST_RESYNC_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    resync_i |=> !locked_o); // R8
endmodule

bind frame_aligner frame_aligner_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .resync_i     (resync_i),
  .err_clr_i    (err_clr_i),
  .word_valid_o (word_valid_o),
  .locked_o     (locked_o),
  .frame_err_o  (frame_err_o)
);

// File: tb/frame_aligner_bench.sv
`timescale 1ns/1ps
module frame_aligner_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] nib_i = '0;
  logic       train_zeros_i = 1'b0;
  logic       resync_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [9:0] word_o;
  logic       word_valid_o;
  logic       locked_o;
  logic       frame_err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic sbits [0:1023];
  int   wp, rp;
  logic [9:0] rx [0:63];
  int   rx_n;

  always #2.5 clk = ~clk;

  frame_aligner u_frame_aligner (
    .clk(clk), .rst(rst), .nib_i(nib_i), .train_zeros_i(train_zeros_i),
    .resync_i(resync_i), .err_clr_i(err_clr_i), .word_o(word_o),
    .word_valid_o(word_valid_o), .locked_o(locked_o), .frame_err_o(frame_err_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_bit(logic b);
    sbits[wp] = b;
    wp++;
  endtask

  task automatic push_frame(logic st, logic [9:0] pay, logic sp);
    push_bit(st);
    for (int i = 9; i >= 0; i--) push_bit(pay[i]);
    push_bit(sp);
  endtask

  task automatic push_train(int n, logic lvl);
    for (int k = 0; k < n; k++) push_frame(1'b1, {10{lvl}}, 1'b0);
  endtask

  task automatic step();
    for (int i = 0; i < 6; i++) nib_i[5-i] = sbits[rp+i];
    rp += 6;
    @(posedge clk);
    #1;
    if (word_valid_o) begin
      if (rx_n < 64) rx[rx_n] = word_o;
      rx_n++;
    end
  endtask

  task automatic run_to(int pos);
    while (rp < pos) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; resync_i = 1'b0; err_clr_i = 1'b0; nib_i = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    wp = 0; rp = 0; rx_n = 0;
  endtask

  // R9 reset state, R2/R3 acquisition at an offset, R4 count, R5 timing, R1 order
  task automatic t_lock(int j, logic zeros, string req);
    logic [9:0] data [0:5];
    logic       lvl;
    int         tw;
    data[0] = 10'h155; data[1] = 10'h2AA; data[2] = 10'h001;
    data[3] = 10'h200; data[4] = 10'h0F0; data[5] = 10'h3C3;
    lvl = ~zeros;
    tw  = lvl ? 10'h3FF : 10'h000;
    do_reset();
    chk("R9", "locked after reset", int'(locked_o), 0);
    chk("R9", "valid after reset", int'(word_valid_o), 0);
    chk("R9", "err after reset", int'(frame_err_o), 0);
    chk("R9", "word after reset", int'(word_o), 0);
    train_zeros_i = zeros;
    for (int k = 0; k < j; k++) push_bit(lvl);
    push_train(10, lvl);
    for (int k = 0; k < 6; k++) push_frame(1'b1, data[k], 1'b0);
    push_train(4, lvl);
    run_to(j + 84);
    chk("R4", "locked after 7 frames", int'(locked_o), 0);
    run_to(j + 96);
    chk(req, "locked after 8 frames", int'(locked_o), 1);
    run_to(j + 108);
    chk("R5", "valid on frame 9 stop nibble", int'(word_valid_o), 1);
    chk("R5", "training word", int'(word_o), tw);
    run_to(j + 192);
    chk("R5", "word count frames 9-16", rx_n, 8);
    chk("R1", "second training word", int'(rx[1]), tw);
    for (int k = 0; k < 6; k++)
      chk("R1", $sformatf("data word %0d at offset %0d", k, j), int'(rx[2+k]), int'(data[k]));
  endtask

  // R3 all-ones pattern must not lock when zeros selected
  task automatic t_wrong_pattern();
    do_reset();
    train_zeros_i = 1'b1;
    for (int k = 0; k < 4; k++) push_bit(1'b1);
    push_train(14, 1'b1);
    run_to(4 + 144);
    chk("R3", "no lock on ones pattern", int'(locked_o), 0);
    chk("R3", "no words on ones pattern", rx_n, 0);
    train_zeros_i = 1'b0;
  endtask

  // R4 bad frame during confirmation restarts the search
  task automatic t_abort();
    int j;
    j = 2;
    do_reset();
    for (int k = 0; k < j; k++) push_bit(1'b1);
    push_train(7, 1'b1);
    push_frame(1'b1, 10'h3FF, 1'b1);
    push_train(12, 1'b1);
    run_to(j + 132);
    chk("R4", "no lock 3 frames after abort", int'(locked_o), 0);
    chk("R5", "no word before lock", rx_n, 0);
    run_to(j + 180);
    chk("R4", "no lock 7 frames after abort", int'(locked_o), 0);
    run_to(j + 192);
    chk("R4", "lock 8 frames after abort", int'(locked_o), 1);
  endtask

  // R6 loss counting, R7 sticky error and clear, R9 reset clears
  task automatic t_loss();
    int j;
    j = 9;
    do_reset();
    for (int k = 0; k < j; k++) push_bit(1'b1);
    push_train(9, 1'b1);
    for (int k = 0; k < 3; k++) push_frame(1'b0, 10'h155, 1'b0);
    push_frame(1'b1, 10'h0F0, 1'b0);
    for (int k = 0; k < 4; k++) push_frame(1'b0, 10'h155, 1'b0);
    push_train(3, 1'b1);
    run_to(j + 96);
    chk("R4", "locked before loss test", int'(locked_o), 1);
    chk("R7", "err clear before faults", int'(frame_err_o), 0);
    run_to(j + 144);
    chk("R6", "still locked after 3 bad", int'(locked_o), 1);
    chk("R7", "err set by bad frame", int'(frame_err_o), 1);
    chk("R5", "no word for bad frames", rx_n, 1);
    run_to(j + 156);
    chk("R5", "word after good frame", rx_n, 2);
    chk("R1", "good frame payload", int'(rx[1]), 10'h0F0);
    chk("R7", "err sticky through good frame", int'(frame_err_o), 1);
    err_clr_i = 1'b1;
    step();
    err_clr_i = 1'b0;
    chk("R7", "err cleared", int'(frame_err_o), 0);
    run_to(j + 192);
    chk("R6", "good frame restarted count", int'(locked_o), 1);
    run_to(j + 204);
    chk("R6", "lock lost after 4 bad", int'(locked_o), 0);
    chk("R7", "err set again", int'(frame_err_o), 1);
    do_reset();
    chk("R9", "reset clears err", int'(frame_err_o), 0);
    chk("R9", "reset clears lock", int'(locked_o), 0);
  endtask

  // R8 resync drops lock and needs a full recount
  task automatic t_resync();
    int j;
    j = 1;
    do_reset();
    for (int k = 0; k < j; k++) push_bit(1'b1);
    push_train(22, 1'b1);
    run_to(j + 96);
    chk("R8", "locked before resync", int'(locked_o), 1);
    resync_i = 1'b1;
    step();
    resync_i = 1'b0;
    chk("R8", "resync drops lock", int'(locked_o), 0);
    run_to(j + 180);
    chk("R8", "no lock after 7 fresh frames", int'(locked_o), 0);
    run_to(j + 192);
    chk("R8", "relock after 8 fresh frames", int'(locked_o), 1);
  endtask

  initial begin
    t_lock(0,  1'b0, "R2");
    t_lock(5,  1'b0, "R2");
    t_lock(7,  1'b0, "R2");
    t_lock(11, 1'b0, "R2");
    t_lock(3,  1'b0, "R2");
    t_lock(4,  1'b1, "R3");
    t_lock(9,  1'b1, "R3");
    t_wrong_pattern();
    t_abort();
    t_loss();
    t_resync();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule